// File: doc/BRIEF.md
# Sixteen-Bit Registered Arithmetic and Logic Unit

This block is the arithmetic and logic stage of a small load/store processor. Each cycle it reads two 16-bit operands, A and B, and a 4-bit operation code. It forms one of eleven results: copy of A, bitwise AND, OR or XOR of A and B, bitwise inverse of A, sum, difference, A plus one, A minus one, a forced zero, or the two's-complement negation of A. All arithmetic wraps modulo 2^16, and any carry or borrow is dropped. The block produces no status flags.

The chosen result goes into an output register on the rising clock edge, but only when the load enable is high. Otherwise the register keeps its value, so the control sequencer can hold a result for later cycles. A synchronous, active-high reset clears the register. Inside, a bitwise unit and a single shared adder each produce a candidate. A final selector picks between them, A, and zero.

Top module: `alu16_core`

## Requirements
- R1: When `rst` is high at a rising edge, `result` becomes 0x0000 after that edge, whatever the value of `ld_en`.
- R2: When `rst` is low and `ld_en` is low at a rising edge, `result` keeps its previous value, whatever the values of `op_sel`, `opnd_a` and `opnd_b`.
- R3: Code 0 (pass) loads A.
- R4: Code 1 loads A AND B, code 2 loads A OR B, code 4 loads A XOR B, and code 3 loads the bitwise inverse of A.
- R5: Code 5 loads (A + B) mod 2^16, and code 6 loads (A − B) mod 2^16. Carry and borrow are discarded.
- R6: Code 7 loads (A + 1) mod 2^16 and code 8 loads (A − 1) mod 2^16. B has no effect on either result.
- R7: Code 9 loads 0x0000, and codes 11 to 15 also load 0x0000, whatever the operands are.
- R8: Code 10 loads (NOT A + 1) mod 2^16. So 0x0000 maps to 0x0000 and 0x8000 maps to 0x8000.
- R9: When `rst` is low and `ld_en` is high at a rising edge, `result` shows the operation selected by the inputs present at that edge. It shows it after that edge, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset of the output register |
| ld_en | input | 1 | Load enable for the output register |
| op_sel | input | 4 | Operation code (0 to 15) |
| opnd_a | input | 16 | Operand A |
| opnd_b | input | 16 | Operand B |
| result | output | 16 | Registered result C |

## Verification
The only state in the block is the output register. A fault in that register shows at the port on the first sampling point after the edge it mishandled. For example, a missed enable leaves a stale word, and a reset that does not take leaves a nonzero word. Faults in the decode or in the shared adder show as a wrong word one edge after the affected code is loaded. The bench aims at the cases where such faults show: the edge values 0x0000, 0xFFFF, 0x8000 and 0x7FFF, with every code applied to them. Those values are where a wrong carry-in or a wrong operand inversion first becomes visible.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_PASS = 4'd0,
        OP_AND  = 4'd1,
        OP_OR   = 4'd2,
        OP_NOT  = 4'd3,
        OP_XOR  = 4'd4,
        OP_ADD  = 4'd5,
        OP_SUB  = 4'd6,
        OP_INC  = 4'd7,
        OP_DEC  = 4'd8,
        OP_ZERO = 4'd9,
        OP_NEG  = 4'd10
    } op_code_e;

    typedef enum logic [1:0] {
        SRC_ZERO  = 2'd0,
        SRC_PASS  = 2'd1,
        SRC_LOGIC = 2'd2,
        SRC_ARITH = 2'd3
    } res_src_e;

endpackage

// File: rtl/alu16_logic.sv
module alu16_logic
    import alu16_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  op_code_e           op,
    input  logic [WIDTH-1:0]   a,
    input  logic [WIDTH-1:0]   b,
    output logic [WIDTH-1:0]   y
);

    // Bitwise group; codes outside the group give zero and are not selected.
    always_comb begin
        case (op)
            OP_AND:  y = a & b;
            OP_OR:   y = a | b;
            OP_XOR:  y = a ^ b;
            OP_NOT:  y = ~a;
            default: y = '0;
        endcase
    end

endmodule

// File: rtl/alu16_arith.sv
module alu16_arith
    import alu16_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  op_code_e           op,
    input  logic [WIDTH-1:0]   a,
    input  logic [WIDTH-1:0]   b,
    output logic [WIDTH-1:0]   y
);

    localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};
    localparam logic [WIDTH-1:0] ONE_LSB  = {{(WIDTH-1){1'b0}}, 1'b1};

    logic [WIDTH-1:0] add_x;
    logic [WIDTH-1:0] add_y;
    logic             add_cin;

    // One shared adder: every arithmetic code becomes x + y + cin.
    always_comb begin
        add_x   = a;
        add_y   = '0;
        add_cin = 1'b0;
        case (op)
            OP_ADD: begin add_y = b;        add_cin = 1'b0; end
            OP_SUB: begin add_y = ~b;       add_cin = 1'b1; end
            OP_INC: begin add_y = '0;       add_cin = 1'b1; end
            OP_DEC: begin add_y = ALL_ONES; add_cin = 1'b0; end
            OP_NEG: begin add_x = ~a; add_y = '0; add_cin = 1'b1; end
            default: begin add_y = '0;      add_cin = 1'b0; end
        endcase
    end

    // Carry out is dropped: the sum is kept at WIDTH bits.
    assign y = add_x + add_y + (add_cin ? ONE_LSB : '0);

endmodule

// File: rtl/alu16_core.sv
module alu16_core
    import alu16_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ld_en,
    input  logic [3:0]       op_sel,
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    output logic [WIDTH-1:0] result
);

    op_code_e         op;
    res_src_e         src;
    logic [WIDTH-1:0] logic_y;
    logic [WIDTH-1:0] arith_y;
    logic [WIDTH-1:0] next_res;

    assign op = op_code_e'(op_sel);

    alu16_logic #(.WIDTH(WIDTH)) u_logic (
        .op (op),
        .a  (opnd_a),
        .b  (opnd_b),
        .y  (logic_y)
    );

    alu16_arith #(.WIDTH(WIDTH)) u_arith (
        .op (op),
        .a  (opnd_a),
        .b  (opnd_b),
        .y  (arith_y)
    );

    // Source decode: one case over the code.
    always_comb begin
        case (op_sel)
            4'd0:                    src = SRC_PASS;
            4'd1, 4'd2, 4'd3, 4'd4:  src = SRC_LOGIC;
            4'd5, 4'd6, 4'd7, 4'd8,
            4'd10:                   src = SRC_ARITH;
            default:                 src = SRC_ZERO;
        endcase
    end

    always_comb begin
        unique case (src)
            SRC_PASS:  next_res = opnd_a;
            SRC_LOGIC: next_res = logic_y;
            SRC_ARITH: next_res = arith_y;
            SRC_ZERO:  next_res = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            result <= '0;
        end else if (ld_en) begin
            result <= next_res;
        end
    end

    // Checks on the output register.
    logic rst_q;
    always_ff @(posedge clk) rst_q <= rst;

    always @(posedge clk) begin
        if (rst_q == 1'b1) begin
            AST_RESET_CLEARS: assert (result == '0); // R1
        end
    end

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !ld_en |=> $stable(result)); // R2

    AST_ZERO_CODES: assert property (@(posedge clk) disable iff (rst)
        (ld_en && (op_sel == 4'd9 || op_sel > 4'd10)) |=> (result == '0)); // R7

    AST_NOT_INVERTS: assert property (@(posedge clk) disable iff (rst)
        (ld_en && op_sel == 4'd3) |=> (result == ~$past(opnd_a))); // R4

    AST_NEG_SUMS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (ld_en && op_sel == 4'd10) |=> (WIDTH'(result + $past(opnd_a)) == '0)); // R8

    AST_PASS_LOADS_A: assert property (@(posedge clk) disable iff (rst)
        (ld_en && op_sel == 4'd0) |=> (result == $past(opnd_a))); // R3

endmodule

// File: tb/alu16_core_test.sv
module alu16_core_test;

    localparam int  W          = 16;
    localparam time CLK_PERIOD = 10ns;

    logic         clk = 1'b0;
    logic         rst;
    logic         ld_en;
    logic [3:0]   op_sel;
    logic [W-1:0] opnd_a;
    logic [W-1:0] opnd_b;
    logic [W-1:0] result;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    alu16_core #(.WIDTH(W)) uut (
        .clk    (clk),
        .rst    (rst),
        .ld_en  (ld_en),
        .op_sel (op_sel),
        .opnd_a (opnd_a),
        .opnd_b (opnd_b),
        .result (result)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [W-1:0] model(input logic [3:0] c, input logic [W-1:0] a, input logic [W-1:0] b);
        logic [W:0] wide;
        case (c)
            4'd0:  return a;
            4'd1:  return a & b;
            4'd2:  return a | b;
            4'd3:  return ~a;
            4'd4:  return a ^ b;
            4'd5:  begin wide = {1'b0, a} + {1'b0, b}; return wide[W-1:0]; end
            4'd6:  begin wide = {1'b0, a} - {1'b0, b}; return wide[W-1:0]; end
            4'd7:  begin wide = {1'b0, a} + 17'd1; return wide[W-1:0]; end
            4'd8:  begin wide = {1'b0, a} - 17'd1; return wide[W-1:0]; end
            4'd10: begin wide = 17'd0 - {1'b0, a}; return wide[W-1:0]; end
            default: return '0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%04h expected 0x%04h", tag, got, exp);
        end
    endtask

    // Drive at the falling edge, sample at the next falling edge.
    task automatic load_op(input logic [3:0] c, input logic [W-1:0] a, input logic [W-1:0] b);
        @(negedge clk);
        op_sel = c; opnd_a = a; opnd_b = b; ld_en = 1'b1; rst = 1'b0;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    function automatic string tag_of(input logic [3:0] c);
        case (c)
            4'd0: return "R3 pass";
            4'd1, 4'd2, 4'd3, 4'd4: return "R4 bitwise";
            4'd5, 4'd6: return "R5 add/sub";
            4'd7, 4'd8: return "R6 inc/dec";
            4'd10: return "R8 negate";
            default: return "R7 zero";
        endcase
    endfunction

    task automatic t_reset;
        @(negedge clk);
        rst = 1'b1; ld_en = 1'b0;
        @(negedge clk);
        check("R1 reset value", result, '0);
        load_op(4'd0, 16'hBEEF, 16'h0);
        @(negedge clk);
        rst = 1'b1; ld_en = 1'b1; op_sel = 4'd0; opnd_a = 16'h1234;
        @(negedge clk);
        check("R1 reset beats load", result, '0);
        rst = 1'b0; ld_en = 1'b0;
    endtask

    task automatic t_hold;
        load_op(4'd5, 16'h1111, 16'h2222);
        check("R9 load add", result, 16'h3333);
        @(negedge clk);
        ld_en = 1'b0; op_sel = 4'd9; opnd_a = 16'hFFFF; opnd_b = 16'hFFFF;
        repeat (3) @(negedge clk);
        check("R2 hold with ld_en low", result, 16'h3333);
    endtask

    task automatic t_latency;
        @(negedge clk);
        op_sel = 4'd0; opnd_a = 16'hA5A5; opnd_b = 16'h0; ld_en = 1'b1;
        #1;
        check("R9 no change before edge", result, 16'h3333);
        @(negedge clk);
        ld_en = 1'b0;
        check("R9 value after edge", result, 16'hA5A5);
    endtask

    task automatic t_corners;
        logic [W-1:0] cv [4];
        cv[0] = 16'h0000; cv[1] = 16'hFFFF; cv[2] = 16'h8000; cv[3] = 16'h7FFF;
        for (int c = 0; c < 16; c++)
            for (int i = 0; i < 4; i++)
                for (int j = 0; j < 4; j++) begin
                    load_op(4'(c), cv[i], cv[j]);
                    check(tag_of(4'(c)), result, model(4'(c), cv[i], cv[j]));
                end
    endtask

    task automatic t_negate_edges;
        load_op(4'd10, 16'h0000, 16'h1234);
        check("R8 negate zero", result, 16'h0000);
        load_op(4'd10, 16'h8000, 16'h1234);
        check("R8 negate 0x8000", result, 16'h8000);
        load_op(4'd10, 16'h0001, 16'h0);
        check("R8 negate one", result, 16'hFFFF);
    endtask

    task automatic t_b_ignored;
        logic [3:0] codes [2];
        codes[0] = 4'd7; codes[1] = 4'd8;
        for (int k = 0; k < 2; k++) begin
            load_op(codes[k], 16'h4321, 16'h0000);
            check("R6 B=0000", result, model(codes[k], 16'h4321, 16'h0));
            load_op(codes[k], 16'h4321, 16'hFFFF);
            check("R6 B=FFFF", result, model(codes[k], 16'h4321, 16'h0));
        end
        load_op(4'd7, 16'hFFFF, 16'h5555);
        check("R6 inc wraps", result, 16'h0000);
        load_op(4'd8, 16'h0000, 16'h5555);
        check("R6 dec wraps", result, 16'hFFFF);
        load_op(4'd5, 16'hFFFF, 16'h0002);
        check("R5 add drops carry", result, 16'h0001);
        load_op(4'd6, 16'h0000, 16'h0001);
        check("R5 sub drops borrow", result, 16'hFFFF);
    endtask

    task automatic t_random;
        for (int n = 0; n < 300; n++) begin
            logic [3:0]   c;
            logic [W-1:0] a;
            logic [W-1:0] b;
            c = 4'($urandom_range(0, 15));
            a = W'($urandom);
            b = W'($urandom);
            load_op(c, a, b);
            check(tag_of(c), result, model(c, a, b));
        end
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        rst = 1'b1; ld_en = 1'b0; op_sel = '0; opnd_a = '0; opnd_b = '0;
        t_reset();
        t_hold();
        t_latency();
        t_corners();
        t_negate_edges();
        t_b_ignored();
        t_random();
        finish_run();
    end

    initial begin
        #(CLK_PERIOD * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

endmodule